// File: doc/BRIEF.md
# Packed Lane Formatting Unit

This unit reshapes the packed lanes held in two 32-bit operands. It widens, narrows (by truncation or by clamping), pairs lanes of two sources into a transposed layout, replicates a scalar across all lanes, and inserts or extracts a single lane picked by an index. The operation is chosen by an opcode. The lane width is given as a base-2 logarithm: code 1 is 2-bit lanes, 2 is 4-bit, 3 is 8-bit, 4 is 16-bit and 5 is 32-bit. A signedness bit selects sign or zero extension, or signed or unsigned clamping.

The result is computed combinationally from the request and captured in a 64-bit register. A two-state controller tracks whether that register holds a fresh result. `S_IDLE` moves to `S_HOLD` on the *accept* transition (`in_valid` high). `S_HOLD` stays in `S_HOLD` on the *chain* transition (another request in the same cycle) and returns to `S_IDLE` on the *drain* transition (no request). `out_valid` is high exactly in `S_HOLD`. The unit accepts one request per cycle.

Opcodes: 0 widen, 1 narrow, 2 clamping narrow, 3 transpose, 4 duplicate, 5 insert, 6 extract, 7 reserved. Lane i of a register occupies bits [w*i + w-1 : w*i].

Top module: `lane_fmt_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `result` is 0. `out_valid` is 1 in the cycle after an accepted request and 0 after a cycle with no request. With no request, `result` keeps its value.
- R2: Opcode 0 with width code 1 to 4 extends every lane of `rs1` to double width. Source lane i lands at bits [2w*i +: 2w] of the result. The extension is sign extension when `sgn` is 1 and zero extension when it is 0.
- R3: Opcode 1 with width code 2 to 5 keeps the low half of each lane. The halves from `rs1` fill `result[15:0]` and those from `rs2` fill `result[31:16]`, each with lane 0 lowest. `result[63:32]` is 0.
- R4: Opcode 2 with `sgn`=1 treats each source lane as signed and clamps it to the signed half-width range before placing it as in R3.
- R5: Opcode 2 with `sgn`=0 treats each source lane as unsigned and replaces any value above the half-width maximum with all ones, placed as in R3.
- R6: Opcode 3 with width code 1 to 4 builds lane pair j of the low word from `rs1` lane 2j (lower) and `rs2` lane 2j (upper). Lane pair j of the high word is built the same way from lanes 2j+1.
- R7: Opcode 4 with width code 1 to 4 copies `rs1` lane 0 into every lane of `result[31:0]`. The high word is 0.
- R8: Opcode 5 with width code 1 to 4 returns `rs2` with the indexed lane replaced by `rs1` lane 0. The high word is 0.
- R9: Opcode 6 with width code 1 to 4 returns the indexed lane of `rs1` in `result[31:0]`, sign-extended when `sgn` is 1 and zero-extended when it is 0. The high word is 0.
- R10: For opcodes 5 and 6 the lane index is taken modulo the lane count, which means only its low log2(32/w) bits are used.
- R11: Opcode 7, and any width code outside the range listed for an opcode, give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Opcode |
| wcode | input | 3 | Lane width as log2 of bits |
| sgn | input | 1 | Signed extension or clamping |
| idx | input | 4 | Lane index for insert and extract |
| rs1 | input | 32 | First source |
| rs2 | input | 32 | Second source or insert base |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |

## Verification
The hardest cases to reach are clamping at its exact edges and back-to-back requests through the `S_HOLD` chain transition. Clamping can fail by one only on lanes that sit on or just beyond the half-width limits, and uniform random words rarely place such values in the narrow lanes. The directed cases therefore put limit values in specific lanes. The random phase also biases a share of the operands toward all-ones, all-zeros and sign-boundary patterns. Requests are issued with random gaps, so chained and isolated results and the hold-on-idle behaviour are all checked against the bench reference model.

// File: rtl/lane_fmt_pkg.sv
package lane_fmt_pkg;

    typedef enum logic [2:0] {
        OP_WIDEN   = 3'd0,
        OP_NARROW  = 3'd1,
        OP_QNARROW = 3'd2,
        OP_XPOSE   = 3'd3,
        OP_DUP     = 3'd4,
        OP_INSERT  = 3'd5,
        OP_EXTRACT = 3'd6,
        OP_RSVD    = 3'd7
    } lf_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } lf_state_e;

endpackage

// File: rtl/lf_widen.sv
module lf_widen #(
    parameter int DATA_W = 32,
    parameter int LOG_W  = 1
) (
    input  logic [DATA_W-1:0]   src,
    input  logic                sgn,
    output logic [2*DATA_W-1:0] dst
);
    localparam int W = 1 << LOG_W;
    localparam int N = DATA_W / W;

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic ext_bit;
        assign ext_bit = sgn & src[W*i + W-1];
        assign dst[2*W*i +: 2*W] = {{W{ext_bit}}, src[W*i +: W]};
    end
endmodule

// File: rtl/lf_narrow.sv
module lf_narrow #(
    parameter int DATA_W = 32,
    parameter int LOG_W  = 2
) (
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic              sat,
    input  logic              sgn,
    output logic [DATA_W-1:0] dst
);
    localparam int W    = 1 << LOG_W;
    localparam int H    = W / 2;
    localparam int N    = DATA_W / W;
    localparam int HALF = DATA_W / 2;
    localparam logic [H-1:0] SMAX = {1'b0, {(H-1){1'b1}}};
    localparam logic [H-1:0] SMIN = ~SMAX;

    for (genvar s = 0; s < 2; s++) begin : g_src
        for (genvar i = 0; i < N; i++) begin : g_lane
            logic [W-1:0] ln;
            logic [H-1:0] q;
            logic         sfit;
            logic         ufit;
            assign ln   = (s == 0) ? src1[W*i +: W] : src2[W*i +: W];
            assign sfit = (&ln[W-1:H-1]) | ~(|ln[W-1:H-1]);
            assign ufit = ~(|ln[W-1:H]);
            always_comb begin
                if (!sat)        q = ln[H-1:0];
                else if (sgn)    q = sfit ? ln[H-1:0] : (ln[W-1] ? SMIN : SMAX);
                else             q = ufit ? ln[H-1:0] : {H{1'b1}};
            end
            assign dst[HALF*s + H*i +: H] = q;
        end
    end
endmodule

// File: rtl/lf_shuffle.sv
module lf_shuffle #(
    parameter int DATA_W = 32,
    parameter int LOG_W  = 1
) (
    input  logic [DATA_W-1:0]   src1,
    input  logic [DATA_W-1:0]   src2,
    output logic [2*DATA_W-1:0] xpose,
    output logic [DATA_W-1:0]   dup
);
    localparam int W = 1 << LOG_W;
    localparam int N = DATA_W / W;
    localparam int P = N / 2;

    for (genvar j = 0; j < P; j++) begin : g_pair
        assign xpose[2*W*j +: W]              = src1[W*(2*j) +: W];
        assign xpose[2*W*j + W +: W]          = src2[W*(2*j) +: W];
        assign xpose[DATA_W + 2*W*j +: W]     = src1[W*(2*j+1) +: W];
        assign xpose[DATA_W + 2*W*j + W +: W] = src2[W*(2*j+1) +: W];
    end

    for (genvar i = 0; i < N; i++) begin : g_dup
        assign dup[W*i +: W] = src1[W-1:0];
    end
endmodule

// File: rtl/lf_scalar.sv
module lf_scalar #(
    parameter int DATA_W = 32,
    parameter int LOG_W  = 1,
    parameter int LN     = 4
) (
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [LN-1:0]     sel,
    input  logic              sgn,
    output logic [DATA_W-1:0] ins,
    output logic [DATA_W-1:0] ext
);
    localparam int W = 1 << LOG_W;
    localparam int N = DATA_W / W;

    logic [W-1:0] picked;

    for (genvar i = 0; i < N; i++) begin : g_ins
        assign ins[W*i +: W] = (sel == LN'(i)) ? src1[W-1:0] : src2[W*i +: W];
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == LN'(i)) picked = src1[W*i +: W];
        end
    end

    assign ext = {{(DATA_W-W){sgn & picked[W-1]}}, picked};
endmodule

// File: rtl/lane_fmt_unit.sv
module lane_fmt_unit
    import lane_fmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [2:0]          wcode,
    input  logic                sgn,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   rs1,
    input  logic [DATA_W-1:0]   rs2,
    output logic                out_valid,
    output logic [2*DATA_W-1:0] result
);
    localparam int LOG_MAX = $clog2(DATA_W);
    localparam int NCODE   = 8;

    lf_op_e    op_e;
    lf_state_e state_q, state_nx;
    logic      sat_mode;

    logic [2*DATA_W-1:0] wid_r [NCODE];
    logic [2*DATA_W-1:0] xp_r  [NCODE];
    logic [DATA_W-1:0]   nar_r [NCODE];
    logic [DATA_W-1:0]   dup_r [NCODE];
    logic [DATA_W-1:0]   ins_r [NCODE];
    logic [DATA_W-1:0]   ext_r [NCODE];
    logic [2*DATA_W-1:0] res_nx, res_q;

    assign op_e     = lf_op_e'(op);
    assign sat_mode = (op_e == OP_QNARROW);

    for (genvar k = 0; k < NCODE; k++) begin : g_width
        if (k >= 1 && k <= LOG_MAX - 1) begin : g_lanes
            localparam int LNK = LOG_MAX - k;
            lf_widen #(.DATA_W(DATA_W), .LOG_W(k)) u_widen (
                .src (rs1),
                .sgn (sgn),
                .dst (wid_r[k])
            );
            lf_shuffle #(.DATA_W(DATA_W), .LOG_W(k)) u_shuffle (
                .src1  (rs1),
                .src2  (rs2),
                .xpose (xp_r[k]),
                .dup   (dup_r[k])
            );
            lf_scalar #(.DATA_W(DATA_W), .LOG_W(k), .LN(LNK)) u_scalar (
                .src1 (rs1),
                .src2 (rs2),
                .sel  (idx[LNK-1:0]),
                .sgn  (sgn),
                .ins  (ins_r[k]),
                .ext  (ext_r[k])
            );
        end else begin : g_nolanes
            assign wid_r[k] = '0;
            assign xp_r[k]  = '0;
            assign dup_r[k] = '0;
            assign ins_r[k] = '0;
            assign ext_r[k] = '0;
        end

        if (k >= 2 && k <= LOG_MAX) begin : g_nar
            lf_narrow #(.DATA_W(DATA_W), .LOG_W(k)) u_narrow (
                .src1 (rs1),
                .src2 (rs2),
                .sat  (sat_mode),
                .sgn  (sgn),
                .dst  (nar_r[k])
            );
        end else begin : g_nonar
            assign nar_r[k] = '0;
        end
    end

    always_comb begin
        res_nx = '0;
        unique case (op_e)
            OP_WIDEN:               res_nx = wid_r[wcode];
            OP_NARROW, OP_QNARROW:  res_nx = {{DATA_W{1'b0}}, nar_r[wcode]};
            OP_XPOSE:               res_nx = xp_r[wcode];
            OP_DUP:                 res_nx = {{DATA_W{1'b0}}, dup_r[wcode]};
            OP_INSERT:              res_nx = {{DATA_W{1'b0}}, ins_r[wcode]};
            OP_EXTRACT:             res_nx = {{DATA_W{1'b0}}, ext_r[wcode]};
            OP_RSVD:                res_nx = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: accept, chain, drain
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE: state_nx = in_valid ? S_HOLD : S_IDLE;
            S_HOLD: state_nx = in_valid ? S_HOLD : S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= res_nx;
    end

    assign out_valid = (state_q == S_HOLD);
    assign result    = res_q;
endmodule

// File: rtl/lane_fmt_unit_chk.sv
module lane_fmt_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2:0]          op,
    input logic [2:0]          wcode,
    input logic [DATA_W-1:0]   rs1,
    input logic                out_valid,
    input logic [2*DATA_W-1:0] result
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r1_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r3_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1) |=> (result[2*DATA_W-1:DATA_W] == '0));

    a_r7_dup_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4 && wcode == 3'd3)
        |=> (result[DATA_W-1:0] == {(DATA_W/8){$past(rs1[7:0])}}));

    a_r9_extract_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd6) |=> (result[2*DATA_W-1:DATA_W] == '0));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7) |=> (result == '0));
endmodule

bind lane_fmt_unit lane_fmt_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .wcode     (wcode),
    .rs1       (rs1),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/lane_fmt_unit_tb.sv
`timescale 1ns/1ps
module lane_fmt_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [2:0]  wcode = '0;
    logic        sgn = 1'b0;
    logic [3:0]  idx = '0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lane_fmt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wcode(wcode),
        .sgn(sgn), .idx(idx), .rs1(rs1), .rs2(rs2),
        .out_valid(out_valid), .result(result)
    );

    function automatic longint unsigned msk(int w);
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic longint unsigned lane(longint unsigned x, int i, int w);
        return (x >> (w*i)) & msk(w);
    endfunction

    function automatic logic [63:0] ref_fn(int o, int wc, bit sg, int ix,
                                          logic [31:0] a, logic [31:0] b);
        longint unsigned r = 0;
        int w = 1 << wc;
        int n = 32 / w;
        int h = w / 2;
        if ((o == 0 || o == 3 || o == 4 || o == 5 || o == 6) && (wc < 1 || wc > 4)) return 64'd0;
        if ((o == 1 || o == 2) && (wc < 2 || wc > 5)) return 64'd0;
        case (o)
            0: for (int i = 0; i < n; i++) begin
                longint unsigned v = lane(a, i, w);
                if (sg && v[w-1]) v = v | (msk(2*w) & ~msk(w));
                r = r | (v << (2*w*i));
            end
            1, 2: for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < n; i++) begin
                    longint unsigned v = lane(s ? b : a, i, w);
                    longint unsigned q;
                    longint sv = v[w-1] ? longint'(v) - longint'(64'd1 << w) : longint'(v);
                    longint lo = -(longint'(64'd1) << (h-1));
                    longint hi = (longint'(64'd1) << (h-1)) - 1;
                    if (o == 1) q = v & msk(h);
                    else if (sg) begin
                        if (sv > hi) sv = hi;
                        if (sv < lo) sv = lo;
                        q = longint'(sv) & msk(h);
                    end else q = (v > msk(h)) ? msk(h) : v;
                    r = r | (q << (16*s + h*i));
                end
            end
            3: for (int j = 0; j < n/2; j++) begin
                r = r | (lane(a, 2*j, w) << (2*w*j))
                      | (lane(b, 2*j, w) << (2*w*j + w))
                      | (lane(a, 2*j+1, w) << (32 + 2*w*j))
                      | (lane(b, 2*j+1, w) << (32 + 2*w*j + w));
            end
            4: for (int i = 0; i < n; i++) r = r | (lane(a, 0, w) << (w*i));
            5: begin
                int k = ix % n;
                r = longint'(b) & ~(msk(w) << (w*k));
                r = r | (lane(a, 0, w) << (w*k));
            end
            6: begin
                int k = ix % n;
                longint unsigned v = lane(a, k, w);
                if (sg && v[w-1]) v = v | (msk(32) & ~msk(w));
                r = v;
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(int o, int wc, bit sg);
        if (o == 7) return "R11";
        if ((o == 1 || o == 2) && (wc < 2 || wc > 5)) return "R11";
        if (o != 1 && o != 2 && (wc < 1 || wc > 4)) return "R11";
        case (o)
            0: return "R2";
            1: return "R3";
            2: return sg ? "R4" : "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(string tag, int o, int wc, bit sg, int ix,
                         logic [31:0] a, logic [31:0] b);
        logic [63:0] exp;
        @(negedge clk);
        in_valid = 1'b1; op = 3'(o); wcode = 3'(wc); sgn = sg; idx = 4'(ix);
        rs1 = a; rs2 = b;
        exp = ref_fn(o, wc, sg, ix, a, b);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, out_valid === 1'b1 && result === exp, result, exp);
    endtask

    initial begin
        logic [63:0] exp_prev;
        logic [63:0] held;
        bit pend;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", out_valid === 1'b0 && result === 64'd0, result, 64'd0);
        rst_n = 1'b1;

        issue("R2", 0, 1, 1, 0, 32'hE4E4_1B1B, 0);
        issue("R2", 0, 3, 0, 0, 32'h80FF_7F01, 0);
        issue("R2", 0, 4, 1, 0, 32'h8000_7FFF, 0);
        issue("R3", 1, 5, 0, 0, 32'hDEAD_BEEF, 32'h1234_5678);
        issue("R3", 1, 2, 1, 0, 32'hFEDC_BA98, 32'h7654_3210);
        issue("R4", 2, 3, 1, 0, 32'h7F80_F807, 32'h0809_F7F8);
        issue("R4", 2, 5, 1, 0, 32'h0000_8000, 32'hFFFF_7FFF);
        issue("R4", 2, 2, 1, 0, 32'h7812_E3F0, 32'h9A5C_0F1E);
        issue("R5", 2, 4, 0, 0, 32'h00FF_0100, 32'hFFFF_0000);
        issue("R5", 2, 2, 0, 0, 32'h3456_789A, 32'h0123_4F4F);
        issue("R6", 3, 1, 0, 0, 32'h1B1B_E4E4, 32'h5A5A_C3C3);
        issue("R6", 3, 4, 0, 0, 32'hAAAA_BBBB, 32'hCCCC_DDDD);
        issue("R7", 4, 2, 0, 0, 32'h0000_000B, 0);
        issue("R7", 4, 3, 0, 0, 32'h1234_56A5, 0);
        issue("R8", 5, 1, 0, 15, 32'h0000_0002, 32'h0000_0000);
        issue("R8", 5, 3, 0, 3, 32'h0000_00EE, 32'h1122_3344);
        issue("R9", 6, 4, 1, 1, 32'h8001_0002, 0);
        issue("R9", 6, 2, 0, 7, 32'hF000_0000, 0);
        issue("R10", 6, 3, 1, 9, 32'h4433_9911, 0);
        issue("R10", 5, 4, 0, 7, 32'h0000_BEEF, 32'h1111_2222);
        issue("R11", 0, 5, 1, 0, 32'hFFFF_FFFF, 0);
        issue("R11", 1, 1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        issue("R11", 7, 3, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R1: idle cycle drops valid and holds the last result
        held = result;
        @(negedge clk);
        check("R1", out_valid === 1'b0 && result === held, result, held);

        pend = 0;
        exp_prev = '0;
        held = result;
        for (int it = 0; it < 600; it++) begin
            string tg;
            @(negedge clk);
            if (pend) check(tg, out_valid === 1'b1 && result === exp_prev, result, exp_prev);
            else      check("R1", out_valid === 1'b0 && result === held, result, held);
            held = result;
            if ($urandom % 4 != 0) begin
                logic [31:0] a, b;
                int o, wc, ix;
                bit sg;
                a = $urandom; b = $urandom;
                case ($urandom % 6)
                    0: a = 32'hFFFF_FFFF;
                    1: a = 32'h8080_8080 ^ ($urandom & 32'h0101_0101);
                    2: b = 32'h7F7F_7F7F;
                    3: b = 32'h0;
                    default: ;
                endcase
                o = int'($urandom % 8); wc = int'($urandom % 7);
                sg = 1'($urandom); ix = int'($urandom % 16);
                in_valid = 1'b1; op = 3'(o); wcode = 3'(wc); sgn = sg;
                idx = 4'(ix); rs1 = a; rs2 = b;
                exp_prev = ref_fn(o, wc, sg, ix, a, b);
                tg = tag_of(o, wc, sg);
                pend = 1;
            end else begin
                in_valid = 1'b0;
                pend = 0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule